// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

A 16-bit timer/counter assembled from two byte halves and advanced on a machine-cycle tick that a prescaler derives as one clock in every twelve. In timer function it counts machine cycles. In counter function it counts falling edges seen on an external count pin. Both pins are sampled once per machine cycle, so a falling edge is recognised from two consecutive samples and is counted one machine cycle later.

A second external pin, the trigger, either captures the running count into a shared 16-bit capture/reload pair or forces a reload of the count from that pair. In auto-reload mode the same pin can instead pick the counting direction. An overflow flag and an external-event flag are sticky, are only cleared by software, and are ORed into one interrupt line. A small byte-wide write port loads the control bits, the direction-enable bit, the count halves and the capture/reload halves. All state is visible on output ports.

Top module: `capreload_timer`

## Requirements
- R1: After a synchronous active-low reset every register (control byte, direction-enable bit, count, capture/reload pair, both flags) reads 0 and the interrupt is low.
- R2: The machine-cycle tick fires on the 12th rising clock edge after reset is released and every 12 edges after that; in timer function (control bit 1 = 0) with run set, the count advances once per tick.
- R3: At each tick the count pin is sampled; a high sample followed by a low sample at the next tick marks a falling edge, and in counter function (control bit 1 = 1) the count advances at the tick after the one where the edge was marked, so at most once per 24 clocks.
- R4: With the run bit (control bit 2) clear the count does not step; writes and trigger-driven reloads still act.
- R5: Counting up, a step from FFFFh sets the overflow flag (control bit 7) and loads 0000h in capture mode (control bit 0 = 1) or the capture/reload value in auto-reload mode (control bit 0 = 0).
- R6: In capture mode with the external-enable bit (control bit 3) set, a trigger falling edge, detected as in R3, copies the count as it stood before that tick's step into the capture/reload pair and sets the external flag (control bit 6); with external-enable clear the trigger has no effect.
- R7: In auto-reload mode with the direction-enable bit (register 1 bit 0) clear and external-enable set, a trigger falling edge loads the count from the capture/reload pair in place of that tick's step and sets the external flag.
- R8: In auto-reload mode with direction-enable set, the last trigger sample selects up (high) or down (low); counting down, a step at a count equal to the capture/reload value loads FFFFh and sets the overflow flag, and the trigger causes no external event.
- R9: Writing the control byte with a 0 in a flag position clears that flag and a 1 leaves it unchanged; a hardware set in the same cycle wins over the clear.
- R10: The interrupt output is high exactly when either flag is set.
- R11: Writes land on the next clock at addresses 0 control, 1 direction-enable, 2 count low, 3 count high, 4 capture/reload low, 5 capture/reload high; a count write in a tick cycle replaces that tick's step or reload and suppresses its overflow, and a capture wins over a same-cycle capture/reload write.
- R12: With the baud placeholder bit (control bit 4) set the counter counts up, reloads from the capture/reload pair on overflow, sets no flag and ignores the trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write byte |
| cnt_pin | input | 1 | External count pin |
| trig_pin | input | 1 | External trigger / direction pin |
| ctrl_o | output | 8 | Control byte with flags in bits 7 and 6 |
| dcen_o | output | 1 | Direction-enable bit |
| cnt_o | output | 16 | Current count |
| rld_o | output | 16 | Capture/reload pair |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench aims at the wrap points: an up-count leaving FFFFh, where a design taking the wrong target would land on 0000h in auto-reload mode or skip the flag, and a down-count meeting the reload value, where an off-by-one compare wraps one step late. It toggles the pins at periods near 12 and 24 clocks to expose an edge detector that counts a level, or counts one tick early. It races software flag clears and count writes against hardware events in the same cycle, where a design with the wrong priority loses an overflow or steps over a written value, and it runs the baud placeholder with trigger activity to catch stray flag sets.

// File: rtl/capreload_pkg.sv
package capreload_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_DIR    = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_RLD_LO = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_RLD_HI = 3'd5;

    localparam int BIT_EXT = 6;
    localparam int BIT_OVF = 7;

    // Writable control bits, packed so that bit 0 is cap_sel.
    typedef struct packed {
        logic baud;
        logic ext_en;
        logic run;
        logic cnt_sel;
        logic cap_sel;
    } cfg_t;

endpackage

// File: rtl/capreload_prescale.sv
// Machine-cycle tick generator: one single-cycle pulse every TICK_DIV clocks.
// Assumes TICK_DIV >= 2; the first pulse comes on the TICK_DIV-th edge after reset.
module capreload_prescale #(
    parameter int TICK_DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = $clog2(TICK_DIV);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == PW'(TICK_DIV - 1));

    // Free-running divider count.
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2

endmodule

// File: rtl/capreload_sampler.sv
// Pin sampler: takes one sample of an asynchronous pin per tick and marks a
// falling edge when a high sample is followed by a low one. The mark and the
// sample hold until the next tick. Assumes the pin is stable for a machine cycle.
module capreload_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic smp_o,
    output logic fall_o
);
    logic smp_q;
    logic fall_q;

    // Per-tick sample and falling-edge mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q  <= 1'b0;
            fall_q <= 1'b0;
        end else if (tick) begin
            fall_q <= smp_q & ~pin;
            smp_q  <= pin;
        end
    end

    assign smp_o  = smp_q;
    assign fall_o = fall_q;

    AST_FALL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_q) |-> (!smp_q && $past(smp_q))); // R3

endmodule

// File: rtl/capreload_cfg.sv
// Control register bank: holds the writable control bits and the
// direction-enable bit. Flags live in the counting core.
module capreload_cfg
    import capreload_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o,
    output logic              dcen_o
);
    localparam int CFG_W = $bits(cfg_t);

    cfg_t cfg_q;
    logic dcen_q;

    // Byte writes into control and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            dcen_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_CTRL) cfg_q  <= cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == ADR_DIR)  dcen_q <= wr_data[0];
        end
    end

    assign cfg_o  = cfg_q;
    assign dcen_o = dcen_q;

endmodule

// File: rtl/capreload_core.sv
// Counting core: 16-bit count, capture/reload pair and the two sticky flags.
// Acts on ticks for counting and trigger events; register writes act on any
// clock. Priority on the count: write, then trigger reload, then step.
module capreload_core
    import capreload_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  cfg_t              cfg,
    input  logic              dcen,
    input  logic              cnt_fall,
    input  logic              trg_fall,
    input  logic              trg_lvl,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  rld_o,
    output logic              ovf_o,
    output logic              ext_o
);
    logic [CNT_W-1:0] cnt_q, cnt_n, rld_q, rld_n, step_val;
    logic             ovf_q, ext_q, ovf_set, ext_set;
    logic             wr_cnt, wr_ctrl, ext_evt, cap_evt, rel_evt;
    logic             go_down, step, wrap;

    // Event and step decode for this clock.
    always_comb begin
        wr_cnt  = wr_en && (wr_addr == ADR_CNT_LO || wr_addr == ADR_CNT_HI);
        wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
        ext_evt = tick && cfg.ext_en && trg_fall && !cfg.baud && (cfg.cap_sel || !dcen);
        cap_evt = ext_evt && cfg.cap_sel;
        rel_evt = ext_evt && !cfg.cap_sel;
        go_down = !cfg.cap_sel && !cfg.baud && dcen && !trg_lvl;
        step    = tick && cfg.run && (cfg.cnt_sel ? cnt_fall : 1'b1);
    end

    // Next count value for one step, with wrap detection.
    always_comb begin
        if (go_down) begin
            wrap     = (cnt_q == rld_q);
            step_val = wrap ? '1 : cnt_q - 1'b1;
        end else begin
            wrap     = &cnt_q;
            step_val = wrap ? ((cfg.cap_sel && !cfg.baud) ? '0 : rld_q) : cnt_q + 1'b1;
        end
    end

    // Count, capture/reload pair and flag next state.
    always_comb begin
        cnt_n = cnt_q;
        if (wr_cnt) begin
            if (wr_addr == ADR_CNT_LO) cnt_n[DATA_W-1:0]     = wr_data;
            else                       cnt_n[CNT_W-1:DATA_W] = wr_data;
        end else if (rel_evt) begin
            cnt_n = rld_q;
        end else if (step) begin
            cnt_n = step_val;
        end

        rld_n = rld_q;
        if (cap_evt) begin
            rld_n = cnt_q;
        end else if (wr_en && wr_addr == ADR_RLD_LO) begin
            rld_n[DATA_W-1:0] = wr_data;
        end else if (wr_en && wr_addr == ADR_RLD_HI) begin
            rld_n[CNT_W-1:DATA_W] = wr_data;
        end

        ovf_set = step && wrap && !cfg.baud && !wr_cnt && !rel_evt;
        ext_set = ext_evt;
    end

    // State registers; a hardware set beats a same-cycle software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rld_q <= '0;
            ovf_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            rld_q <= rld_n;
            ovf_q <= ovf_set | (ovf_q & (!wr_ctrl | wr_data[BIT_OVF]));
            ext_q <= ext_set | (ext_q & (!wr_ctrl | wr_data[BIT_EXT]));
        end
    end

    assign cnt_o = cnt_q;
    assign rld_o = rld_q;
    assign ovf_o = ovf_q;
    assign ext_o = ext_q;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(wr_en && wr_addr == ADR_CTRL && !wr_data[BIT_OVF])); // R9

    AST_EXT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_q) |-> $past(tick && cfg.ext_en && !cfg.baud)); // R6

    AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.run && !wr_cnt && !rel_evt) |=> $stable(cnt_q)); // R4

    AST_BAUD_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.baud && !wr_ctrl) |=> !$rose(ovf_q) && !$rose(ext_q)); // R12

endmodule

// File: rtl/capreload_timer.sv
// Capture/reload timer-counter top: prescaler, two pin samplers (generated),
// control bank and counting core. Assumes pins are stable for at least one
// machine cycle between changes; writes are byte-wide and act on the next clock.
module capreload_timer
    import capreload_pkg::*;
#(
    parameter int TICK_DIV = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        cnt_pin,
    input  logic        trig_pin,
    output logic [7:0]  ctrl_o,
    output logic        dcen_o,
    output logic [15:0] cnt_o,
    output logic [15:0] rld_o,
    output logic        irq_o
);
    localparam int NPIN = 2;

    logic            tick;
    cfg_t            cfg;
    logic            dcen, ovf, ext;
    logic [NPIN-1:0] pins, smp, fall;

    assign pins = {trig_pin, cnt_pin};

    capreload_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_smp
        capreload_sampler u_smp (
            .clk(clk), .rst_n(rst_n), .tick(tick), .pin(pins[g]),
            .smp_o(smp[g]), .fall_o(fall[g])
        );
    end

    capreload_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg_o(cfg), .dcen_o(dcen)
    );

    capreload_core u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg), .dcen(dcen),
        .cnt_fall(fall[0]), .trg_fall(fall[1]), .trg_lvl(smp[1]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_o(cnt_o), .rld_o(rld_o), .ovf_o(ovf), .ext_o(ext)
    );

    assign ctrl_o = {ovf, ext, 1'b0, cfg};
    assign dcen_o = dcen;
    assign irq_o  = ovf | ext;

    AST_IRQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (ctrl_o[7] || ctrl_o[6])); // R10

endmodule

// File: tb/capreload_timer_test.sv
module capreload_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        cnt_pin = 1'b0;
    logic        trig_pin = 1'b0;
    logic [7:0]  ctrl_o;
    logic        dcen_o;
    logic [15:0] cnt_o, rld_o;
    logic        irq_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    logic  checking = 1'b0;

    always #10 clk = ~clk;

    capreload_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .ctrl_o(ctrl_o), .dcen_o(dcen_o), .cnt_o(cnt_o), .rld_o(rld_o),
        .irq_o(irq_o)
    );

    // ---------------- reference model ----------------
    int          m_pre;
    logic        m_cs, m_cf, m_ts, m_tf, m_dcen, m_ovf, m_ext;
    logic [4:0]  m_cfg;
    logic [15:0] m_cnt, m_rld;

    // One step of the count: returns {wrap, next}.
    function automatic logic [16:0] f_step(logic [15:0] c, logic [15:0] r,
                                           logic down, logic to_zero);
        if (down) return (c == r) ? {1'b1, 16'hFFFF} : {1'b0, c - 16'd1};
        if (c == 16'hFFFF) return {1'b1, (to_zero ? 16'h0000 : r)};
        return {1'b0, c + 16'd1};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_cs = 0; m_cf = 0; m_ts = 0; m_tf = 0;
            m_dcen = 0; m_ovf = 0; m_ext = 0; m_cfg = '0; m_cnt = '0; m_rld = '0;
        end else begin
            logic tk, capsel, cntsel, run, exten, baud, wcnt, wctl, evt, down, stp;
            logic [16:0] sv;
            logic [15:0] ncnt, nrld;
            logic        oset;
            tk = (m_pre == 11);
            capsel = m_cfg[0]; cntsel = m_cfg[1]; run = m_cfg[2];
            exten = m_cfg[3]; baud = m_cfg[4];
            wcnt = wr_en && (wr_addr == 3'd2 || wr_addr == 3'd3);
            wctl = wr_en && (wr_addr == 3'd0);
            evt  = tk && exten && m_tf && !baud && (capsel || !m_dcen);
            down = !capsel && !baud && m_dcen && !m_ts;
            stp  = tk && run && (cntsel ? m_cf : 1'b1);
            sv   = f_step(m_cnt, m_rld, down, capsel && !baud);
            ncnt = m_cnt;
            if (wcnt) begin
                if (wr_addr == 3'd2) ncnt[7:0] = wr_data; else ncnt[15:8] = wr_data;
            end else if (evt && !capsel) ncnt = m_rld;
            else if (stp) ncnt = sv[15:0];
            nrld = m_rld;
            if (evt && capsel) nrld = m_cnt;
            else if (wr_en && wr_addr == 3'd4) nrld[7:0] = wr_data;
            else if (wr_en && wr_addr == 3'd5) nrld[15:8] = wr_data;
            oset = stp && sv[16] && !baud && !wcnt && !(evt && !capsel);
            m_ovf = oset | (m_ovf & (!wctl | wr_data[7]));
            m_ext = evt  | (m_ext & (!wctl | wr_data[6]));
            m_cnt = ncnt; m_rld = nrld;
            if (wctl) m_cfg = wr_data[4:0];
            if (wr_en && wr_addr == 3'd1) m_dcen = wr_data[0];
            if (tk) begin
                m_cf = m_cs & ~cnt_pin; m_cs = cnt_pin;
                m_tf = m_ts & ~trig_pin; m_ts = trig_pin;
            end
            m_pre = tk ? 0 : m_pre + 1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle full-state comparison against the model, tagged with the phase.
    always @(negedge clk) begin
        if (rst_n && checking)
            chk(cur_req, {22'd0, ctrl_o, dcen_o, irq_o, rld_o, cnt_o},
                {22'd0, m_ovf, m_ext, 1'b0, m_cfg, m_dcen, (m_ovf | m_ext), m_rld, m_cnt});
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wave(input logic on_trig, input int half, input int n);
        for (int i = 0; i < n; i++) begin
            if (on_trig) trig_pin = ~trig_pin; else cnt_pin = ~cnt_pin;
            idle(half);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd715));
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        chk("R1 ctrl", 64'(ctrl_o), 64'h0);
        chk("R1 cnt",  64'(cnt_o),  64'h0);
        chk("R1 rld",  64'(rld_o),  64'h0);
        chk("R1 irq",  64'({dcen_o, irq_o}), 64'h0);
        checking = 1'b1;

        cur_req = "R2";                     // timer, auto-reload, run
        wr(3'd0, 8'h04); idle(80);
        chk("R2 count advanced", 64'(cnt_o != 16'd0), 64'd1);

        cur_req = "R4";                     // stopped
        wr(3'd0, 8'h00); idle(60);

        cur_req = "R11";                    // loads
        wr(3'd2, 8'hF8); wr(3'd3, 8'hFF); wr(3'd4, 8'h34); wr(3'd5, 8'h12);
        chk("R11 cnt write", 64'(cnt_o), 64'hFFF8);
        chk("R11 rld write", 64'(rld_o), 64'h1234);

        cur_req = "R5";                     // up overflow to reload value
        wr(3'd0, 8'h04); idle(12 * 10);
        cur_req = "R10";
        chk("R10 irq after overflow", 64'(irq_o), 64'(m_ovf | m_ext));
        cur_req = "R9";                     // flag clear (write 1 keeps it)
        wr(3'd0, 8'h84); wr(3'd0, 8'h00);
        chk("R9 flags cleared", 64'(ctrl_o), 64'h0);
        cur_req = "R5";                     // capture-mode overflow to zero
        wr(3'd2, 8'hFC); wr(3'd3, 8'hFF); wr(3'd0, 8'h05); idle(12 * 8);

        cur_req = "R11";                    // count writes racing ticks
        for (int i = 0; i < 30; i++) begin wr(3'd2, 8'(i * 7)); idle(i % 5); end

        cur_req = "R3";                     // counter function, several periods
        wr(3'd0, 8'h06);
        wave(1'b0, 12, 20); wave(1'b0, 6, 20); wave(1'b0, 24, 10); wave(1'b0, 17, 14);

        cur_req = "R6";                     // capture on trigger
        wr(3'd0, 8'h0D);
        wave(1'b1, 30, 12);
        wr(3'd0, 8'h05); wave(1'b1, 30, 6);  // ext_en clear: ignored

        cur_req = "R7";                     // trigger reload
        wr(3'd1, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h80); wr(3'd0, 8'h0C);
        wave(1'b1, 40, 10);

        cur_req = "R8";                     // direction from trigger
        wr(3'd0, 8'h0C); wr(3'd1, 8'h01); wr(3'd4, 8'h05); wr(3'd5, 8'h00);
        wr(3'd2, 8'h09); wr(3'd3, 8'h00);
        trig_pin = 1'b0; idle(12 * 12);
        trig_pin = 1'b1; idle(12 * 6);
        trig_pin = 1'b0; wave(1'b1, 36, 6);

        cur_req = "R12";                    // baud placeholder
        wr(3'd1, 8'h00); wr(3'd0, 8'h1C);
        wr(3'd2, 8'hF0); wr(3'd3, 8'hFF);
        wave(1'b1, 20, 20);

        cur_req = "R9";                     // clear racing hardware set
        wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF);
        wr(3'd0, 8'h04);
        for (int i = 0; i < 40; i++) wr(3'd0, 8'h04);

        cur_req = "R11";                    // constrained random mix
        for (int i = 0; i < 30000; i++) begin
            int r;
            r = $urandom % 64;
            if (r < 3) begin
                logic [2:0] a;
                logic [7:0] d;
                a = 3'($urandom % 6);
                d = 8'($urandom);
                if (a == 3'd0) d[2] = ($urandom % 4) != 0;
                if (a == 3'd3 && ($urandom % 2)) d = 8'hFF;
                wr(a, d);
            end else begin
                if ($urandom % 19 == 0) cnt_pin = ~cnt_pin;
                if ($urandom % 29 == 0) trig_pin = ~trig_pin;
                idle(1);
            end
        end

        checking = 1'b0;
        summary();
        $finish;
    end

endmodule